// File: doc/BRIEF.md
# Edge-Coded Pulse Encoder with Level Refresh

This block sits on the transmit side of a digital isolation channel. It samples a single logic input through a synchronizer and emits a one-cycle pulse on one of two lines for every change of that input. A rising change pulses the set line and a falling change pulses the clear line. A receiver with a bistable latch rebuilds the level from these pulses.

A constant input produces no edges, so the block also sends refresh pulses. After a fixed number of cycles with no pulse, it repeats the present level as a pulse: set when the input is high, clear when it is low. It keeps doing so every interval while the input stays still. This keeps the far side correct for a DC input, and lets a far side that powered up late catch up.

A power-good input gates the whole block. While power is not valid, both pulse lines stay low and the idle timer is held at zero. Once power becomes valid, the block sends one pulse that shows the current level and then runs normally.

The controller has three states:
- `ST_LOCKOUT`: idle.
- `ST_PRIME`: sends the level pulse after lockout.
- `ST_RUN`: edge and refresh encoding.

Its transitions are:
- `LOCKOUT->PRIME` when power-good is high.
- `PRIME->RUN` unconditionally with power.
- `RUN->RUN` while powered.
- Any state `->LOCKOUT` when power-good is low.

Top module: `edge_pulse_encoder`

## Requirements
- R1: A 0-to-1 change on `din_i`, in state RUN, gives exactly one set pulse. The pulse is high in the third clock cycle after the edge where the new value is first sampled: two synchronizer stages, then one output register.
- R2: A 1-to-0 change on `din_i`, in state RUN, gives exactly one clear pulse with the same latency as R1.
- R3: Each pulse is high for exactly one cycle. `set_pls_o` and `clr_pls_o` are never high in the same cycle, and no pulse occurs without an edge, refresh or wake-up cause.
- R4: After REFRESH_CYCLES cycles with no pulse, the block emits a refresh pulse that encodes the synchronized input level: set when it is 1, clear when it is 0.
- R5: With a constant input, refresh pulses repeat exactly every REFRESH_CYCLES cycles.
- R6: If an edge and a refresh fall due in the same cycle, only the edge pulse is sent. The idle count restarts from every pulse of any kind.
- R7: While `pwr_ok_i` is low, both pulse lines are low from the next cycle on and the idle timer stays at zero. The count therefore restarts in full after power returns.
- R8: When `pwr_ok_i` is sampled high in LOCKOUT, the block enters PRIME. It then emits one level-encoding pulse one cycle later, as set if the synchronized input is 1 and as clear if it is 0, and enters RUN.
- R9: After reset both pulse lines are low and the block is in LOCKOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Power-good; low holds the block in lockout |
| din_i | input | 1 | Asynchronous logic input to encode |
| set_pls_o | output | 1 | One-cycle pulse: rising edge or high-level refresh |
| clr_pls_o | output | 1 | One-cycle pulse: falling edge or low-level refresh |

## Verification
The bench builds the block with REFRESH_CYCLES set to 8. With that setting a full refresh interval takes only a few cycles, so the sweeps can place an input edge at every gap from one cycle up to beyond two intervals. That range includes the exact cycle where an edge and a refresh collide. The same sweep drops power-good at every offset within an interval and powers up with both input levels. Every cycle's outputs are compared against a reference model written from the requirements.

// File: rtl/epe_pkg.sv
package epe_pkg;
    typedef enum logic [1:0] {
        ST_LOCKOUT = 2'd0,
        ST_PRIME   = 2'd1,
        ST_RUN     = 2'd2
    } epe_state_t;

    typedef enum logic [1:0] {
        PK_NONE    = 2'd0,
        PK_EDGE    = 2'd1,
        PK_REFRESH = 2'd2,
        PK_WAKE    = 2'd3
    } epe_cause_t;
endpackage

// File: rtl/epe_sync.sv
module epe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/epe_idle_timer.sv
module epe_idle_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic due_o
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr_i)        cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign due_o = (cnt_q == LAST);

    // R7 / R5: count stays in range and a clear always lands at zero
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/edge_pulse_encoder.sv
module edge_pulse_encoder #(
    parameter int REFRESH_CYCLES = 100,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok_i,
    input  logic din_i,
    output logic set_pls_o,
    output logic clr_pls_o
);
    import epe_pkg::*;

    epe_state_t state_q, state_d;
    epe_cause_t cause;
    logic       din_s;
    logic       last_q;
    logic       due;
    logic       emit;
    logic       emit_lvl;

    epe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (din_i),
        .q_o   (din_s)
    );

    epe_idle_timer #(.LIMIT(REFRESH_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (emit || (state_q != ST_RUN) || !pwr_ok_i),
        .due_o (due)
    );

    // next state and pulse cause
    always_comb begin
        state_d  = state_q;
        cause    = PK_NONE;
        if (!pwr_ok_i) begin
            state_d = ST_LOCKOUT;
        end else begin
            unique case (state_q)
                ST_LOCKOUT: state_d = ST_PRIME;
                ST_PRIME: begin
                    state_d = ST_RUN;
                    cause   = PK_WAKE;
                end
                ST_RUN: begin
                    if (din_s != last_q) cause = PK_EDGE;
                    else if (due)        cause = PK_REFRESH;
                end
                default: state_d = ST_LOCKOUT;
            endcase
        end
    end

    assign emit     = (cause != PK_NONE);
    assign emit_lvl = din_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKOUT;
        else        state_q <= state_d;
    end

    // outputs and level tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_pls_o <= 1'b0;
            clr_pls_o <= 1'b0;
            last_q    <= 1'b0;
        end else begin
            set_pls_o <= emit &&  emit_lvl;
            clr_pls_o <= emit && !emit_lvl;
            if (emit) last_q <= emit_lvl;
        end
    end

    // R3: never both lines at once
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_pls_o && clr_pls_o));
    // R3: pulses are one cycle wide
    a_r3_set_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        set_pls_o |=> !set_pls_o);
    a_r3_clr_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pls_o |=> !clr_pls_o);
    // R7: lockout silences both lines
    a_r7_lockout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> (!set_pls_o && !clr_pls_o));
    // R1: a rising synchronized input in steady run gives a set pulse
    a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok_i && state_q == ST_RUN && $past(state_q) == ST_RUN && $rose(din_s))
        |=> set_pls_o);
    // R2: a falling synchronized input in steady run gives a clear pulse
    a_r2_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok_i && state_q == ST_RUN && $past(state_q) == ST_RUN && $fell(din_s))
        |=> clr_pls_o);
    // R8: prime always yields one pulse
    a_r8_prime_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME && pwr_ok_i) |=> $countones({set_pls_o, clr_pls_o}) == 1);

    initial begin
        a_r5_param_ok: assert (REFRESH_CYCLES >= 2 && SYNC_STAGES >= 1);
    end
endmodule

// File: tb/edge_pulse_encoder_bench.sv
module edge_pulse_encoder_bench;
    localparam int R = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0;
    logic din = 1'b0;
    logic set_pls, clr_pls;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    edge_pulse_encoder #(.REFRESH_CYCLES(R), .SYNC_STAGES(2)) u_edge_pulse_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok_i  (pwr_ok),
        .din_i     (din),
        .set_pls_o (set_pls),
        .clr_pls_o (clr_pls)
    );

    // reference model from the requirements
    logic m_s1 = 0, m_s2 = 0, m_last = 0;
    logic e_set = 0, e_clr = 0;
    int   m_ph = 0;
    int   m_idle = 0;
    string e_tag = "R9";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_last <= 0; m_ph <= 0; m_idle <= 0;
            e_set <= 0; e_clr <= 0; e_tag <= "R9";
        end else begin
            m_s1 <= din;
            m_s2 <= m_s1;
            e_set <= 0; e_clr <= 0;
            if (!pwr_ok) begin
                m_ph <= 0; m_idle <= 0; e_tag <= "R7";
            end else if (m_ph == 0) begin
                m_ph <= 1; m_idle <= 0; e_tag <= "R8";
            end else if (m_ph == 1) begin
                m_ph <= 2; m_idle <= 0; m_last <= m_s2;
                e_set <= m_s2; e_clr <= !m_s2; e_tag <= "R8";
            end else if (m_s2 != m_last) begin
                m_last <= m_s2; e_set <= m_s2; e_clr <= !m_s2;
                e_tag <= (m_idle == R-1) ? "R6" : (m_s2 ? "R1" : "R2");
                m_idle <= 0;
            end else if (m_idle == R-1) begin
                e_set <= m_s2; e_clr <= !m_s2; e_tag <= "R4/R5";
                m_idle <= 0;
            end else begin
                m_idle <= m_idle + 1; e_tag <= "R3";
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (set_pls !== e_set || clr_pls !== e_clr) begin
                errors++;
                $display("FAIL %s: set/clr actual %b%b expected %b%b at %0t",
                         e_tag, set_pls, clr_pls, e_set, e_clr, $time);
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    int pulses;
    always @(negedge clk) if (rst_n && (set_pls || clr_pls)) pulses++;

    initial begin
        fork
            begin
                // R9: reset state
                wait_cyc(3);
                checks++;
                if (set_pls !== 0 || clr_pls !== 0) begin
                    errors++;
                    $display("FAIL R9: outputs %b%b expected 00", set_pls, clr_pls);
                end
                rst_n = 1;
                wait_cyc(5);
                // R7: held in lockout, no pulses for a long time
                pulses = 0;
                wait_cyc(3*R);
                checks++;
                if (pulses != 0) begin
                    errors++;
                    $display("FAIL R7: %0d pulses in lockout expected 0", pulses);
                end
                // R8: power up with low input, then high input
                for (int lv = 0; lv < 2; lv++) begin
                    pwr_ok = 0; din = lv[0]; wait_cyc(4);
                    pwr_ok = 1; wait_cyc(2*R + 3);
                end
                // R5: constant hold, count refreshes in 5 intervals
                wait_cyc(1);
                pulses = 0;
                wait_cyc(5*R);
                checks++;
                if (pulses != 5) begin
                    errors++;
                    $display("FAIL R5: %0d refreshes expected 5", pulses);
                end
                // R1 R2 R6: edge at every gap, including collision with refresh
                for (int g = 1; g <= 2*R + 3; g++) begin
                    din = ~din; wait_cyc(g);
                end
                // R3: toggle every cycle
                for (int k = 0; k < 20; k++) begin
                    din = ~din; wait_cyc(1);
                end
                // R7 R8: drop power at every offset within an interval
                for (int off = 0; off <= R + 1; off++) begin
                    din = ~din; wait_cyc(off);
                    pwr_ok = 0; wait_cyc(1 + off % 3);
                    pwr_ok = 1; wait_cyc(R + 4);
                end
                wait_cyc(3*R);
            end
            begin
                wait_cyc(100000);
                errors++;
                $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule